// File: doc/BRIEF.md
# Byte-Stream Host Command Bridge

This block sits between two byte-wide FIFOs that face a host and a simple internal register bus with 8-bit addresses and 16-bit data. It pops bytes from the incoming FIFO, pairs them into 16-bit words, and interprets the word stream as commands. The commands are no-op, ping, multi-word write and multi-word read. Bus accesses are one cycle each. Any data going back to the host is split into bytes and pushed into the outgoing FIFO.

A command word holds the opcode in its upper byte and an operand in its lower byte. For ping, the operand is a payload. For read and write, it is a bus address. Reads and writes are followed by a length word. A write then carries that many data words. A read returns that many result words. Repeated accesses all target the same address, as with a data port register. Flow control is honoured on both sides: the block never pops an empty input FIFO, never pushes into a full output FIFO, and stalls without losing data.

Top module: `hostcmd_bridge`

## Requirements
- R1: Each 16-bit word crosses either byte FIFO as two bytes: bits 15:8 first, then bits 7:0. This holds for incoming commands and data and for outgoing responses.
- R2: A command word with upper byte 0x00 is a no-op. It consumes only that word, makes no bus access and produces no output bytes.
- R3: A command word with upper byte 0x01 is a ping. It produces exactly one output word, equal to 0x01 in the upper byte and the received lower byte in the lower byte.
- R4: A command word with upper byte 0x03 is a write. Its lower byte is the address, and the next word is a count N. The next N words are each written to that address, one bus write strobe per word, in arrival order.
- R5: A command word with upper byte 0x02 is a read. Its lower byte is the address, and the next word is a count N. The block performs N single-cycle bus reads of that address and pushes each returned 16-bit value as one output word, in order.
- R6: A count of zero for a read or write ends the command after the count word, with no bus access and no output bytes. The next word is decoded as a new command.
- R7: A command word with any other upper byte consumes only its own word and has no other effect.
- R8: The output push strobe is never asserted while the output FIFO reports full. While blocked, the pending byte stays stable and no further bus read is issued, so no data is lost.
- R9: The input pop strobe is never asserted while the input FIFO reports empty. Gaps in the input stream delay decoding but do not change its result.
- R10: The bus read and bus write strobes are never asserted in the same cycle. After reset, no strobe is active until input bytes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_byte | input | 8 | Head byte of incoming first-word-fall-through FIFO |
| in_empty | input | 1 | Incoming FIFO has no byte |
| in_pop | output | 1 | Consume the head byte of the incoming FIFO |
| out_byte | output | 8 | Byte to write into outgoing FIFO |
| out_full | input | 1 | Outgoing FIFO cannot accept a byte |
| out_push | output | 1 | Write strobe for outgoing FIFO, one cycle per byte |
| bus_addr | output | 8 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_wr | output | 1 | Bus write strobe, one cycle per access |
| bus_rd | output | 1 | Bus read strobe, one cycle per access |
| bus_rdata | input | 16 | Bus read data, valid in the cycle bus_rd is high |

## Verification
The hardest case to reach is an output FIFO that fills in the middle of a multi-word read. The block must then hold one half-sent result word, keep its lower byte stable, and withhold the next bus read until space returns. The bench models the outgoing FIFO with an adjustable capacity. It sets the capacity to one byte, issues a three-word read, and confirms that exactly one byte and one bus read happen during a long stall. It then raises the capacity and checks that all six bytes arrive in order. Input gaps are produced by a mode that reports empty on alternate cycles while a write is streamed in.

// File: rtl/hcb_pkg.sv
// Package: shared types and opcodes for the host command bridge.
// Assumes commands use an 8-bit opcode in the upper byte of a word.
package hcb_pkg;
    typedef enum logic [2:0] {
        ST_CMD,
        ST_LEN,
        ST_WR,
        ST_RD,
        ST_PING
    } hcb_state_e;

    localparam logic [7:0] OPC_NOP  = 8'h00;
    localparam logic [7:0] OPC_PING = 8'h01;
    localparam logic [7:0] OPC_READ = 8'h02;
    localparam logic [7:0] OPC_WRITE = 8'h03;
endpackage

// File: rtl/hcb_word_rx.sv
// Word assembler: pops bytes from a first-word-fall-through FIFO and
// joins pairs (upper byte first) into one buffered word.
// Assumes the consumer clears the buffer with word_take; no pop while full
// or while the FIFO reports empty.
module hcb_word_rx #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_empty,
    output logic              in_pop,
    output logic [WORD_W-1:0] word,
    output logic              word_valid,
    input  logic              word_take
);
    logic              half_q;
    logic [BYTE_W-1:0] hi_q;
    logic [WORD_W-1:0] word_q;
    logic              valid_q;

    // Pop only when a byte exists and no finished word waits
    assign in_pop     = !in_empty && !valid_q;
    assign word       = word_q;
    assign word_valid = valid_q;

    // Collect the upper byte, then complete the word on the lower byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q  <= 1'b0;
            hi_q    <= '0;
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (word_take) begin
                valid_q <= 1'b0;
            end
            if (in_pop) begin
                if (!half_q) begin
                    hi_q   <= in_byte;
                    half_q <= 1'b1;
                end else begin
                    word_q  <= {hi_q, in_byte};
                    valid_q <= 1'b1;
                    half_q  <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/hcb_word_tx.sv
// Word splitter: takes one word and pushes it as two bytes, upper first,
// into an outgoing FIFO. Assumes load is only raised while ready is high.
module hcb_word_tx #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              ready,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_push,
    input  logic              out_full
);
    logic              busy_q;
    logic              lo_q;
    logic [WORD_W-1:0] word_q;

    assign ready    = !busy_q;
    assign out_push = busy_q && !out_full;
    // Select the upper byte first, the lower byte second
    assign out_byte = lo_q ? word_q[BYTE_W-1:0] : word_q[WORD_W-1:BYTE_W];

    // Hold the word until both bytes have been accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            lo_q   <= 1'b0;
            word_q <= '0;
        end else if (load && !busy_q) begin
            word_q <= word;
            busy_q <= 1'b1;
            lo_q   <= 1'b0;
        end else if (out_push) begin
            if (!lo_q) begin
                lo_q <= 1'b1;
            end else begin
                lo_q   <= 1'b0;
                busy_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hcb_ctrl.sv
// Command sequencer: decodes command words, counts data words and drives
// one-cycle bus strobes at a fixed address. Assumes bus read data is valid
// in the cycle of the read strobe.
module hcb_ctrl
    import hcb_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic              word_valid,
    output logic              word_take,
    input  logic              tx_ready,
    output logic              tx_load,
    output logic [WORD_W-1:0] tx_word,
    output logic [BYTE_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [WORD_W-1:0] bus_rdata
);
    hcb_state_e        state_q;
    logic [BYTE_W-1:0] operand_q;
    logic [WORD_W-1:0] count_q;
    logic              is_rd_q;
    logic [BYTE_W-1:0] opcode;

    assign opcode    = word[WORD_W-1:BYTE_W];
    assign bus_addr  = operand_q;
    assign bus_wdata = word;

    // Strobes and handshakes for the current state
    always_comb begin
        word_take = 1'b0;
        tx_load   = 1'b0;
        tx_word   = bus_rdata;
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        unique case (state_q)
            ST_CMD, ST_LEN: word_take = word_valid;
            ST_WR: begin
                word_take = word_valid;
                bus_wr    = word_valid;
            end
            ST_RD: begin
                bus_rd  = tx_ready;
                tx_load = tx_ready;
            end
            ST_PING: begin
                tx_load = tx_ready;
                tx_word = {BYTE_W'(OPC_PING), operand_q};
            end
            default: ;
        endcase
    end

    // State, operand and remaining-count updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_CMD;
            operand_q <= '0;
            count_q   <= '0;
            is_rd_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_CMD: if (word_valid) begin
                    operand_q <= word[BYTE_W-1:0];
                    if (opcode == BYTE_W'(OPC_PING)) begin
                        state_q <= ST_PING;
                    end else if (opcode == BYTE_W'(OPC_READ)) begin
                        is_rd_q <= 1'b1;
                        state_q <= ST_LEN;
                    end else if (opcode == BYTE_W'(OPC_WRITE)) begin
                        is_rd_q <= 1'b0;
                        state_q <= ST_LEN;
                    end
                end
                ST_LEN: if (word_valid) begin
                    count_q <= word;
                    if (word == '0) begin
                        state_q <= ST_CMD;
                    end else begin
                        state_q <= is_rd_q ? ST_RD : ST_WR;
                    end
                end
                ST_WR: if (word_valid) begin
                    count_q <= count_q - 1'b1;
                    if (count_q == WORD_W'(1)) state_q <= ST_CMD;
                end
                ST_RD: if (tx_ready) begin
                    count_q <= count_q - 1'b1;
                    if (count_q == WORD_W'(1)) state_q <= ST_CMD;
                end
                ST_PING: if (tx_ready) state_q <= ST_CMD;
                default: state_q <= ST_CMD;
            endcase
        end
    end
endmodule

// File: rtl/hostcmd_bridge.sv
// Top: byte-stream host command bridge. Joins input bytes into words,
// sequences commands onto a register bus and splits responses into bytes.
// Assumes first-word-fall-through input FIFO and full-flagged output FIFO.
module hostcmd_bridge #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_empty,
    output logic              in_pop,
    output logic [BYTE_W-1:0] out_byte,
    input  logic              out_full,
    output logic              out_push,
    output logic [BYTE_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [WORD_W-1:0] bus_rdata
);
    logic [WORD_W-1:0] rx_word;
    logic              rx_valid;
    logic              rx_take;
    logic              tx_ready;
    logic              tx_load;
    logic [WORD_W-1:0] tx_word;

    hcb_word_rx #(.BYTE_W(BYTE_W)) i_rx (
        .clk(clk), .rst_n(rst_n),
        .in_byte(in_byte), .in_empty(in_empty), .in_pop(in_pop),
        .word(rx_word), .word_valid(rx_valid), .word_take(rx_take)
    );

    hcb_ctrl #(.BYTE_W(BYTE_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .word(rx_word), .word_valid(rx_valid), .word_take(rx_take),
        .tx_ready(tx_ready), .tx_load(tx_load), .tx_word(tx_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    hcb_word_tx #(.BYTE_W(BYTE_W)) i_tx (
        .clk(clk), .rst_n(rst_n),
        .load(tx_load), .word(tx_word), .ready(tx_ready),
        .out_byte(out_byte), .out_push(out_push), .out_full(out_full)
    );
endmodule

// File: rtl/hcb_checker.sv
// Checker: protocol properties of the host command bridge, bound to the top.
module hcb_checker #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_empty,
    input logic              in_pop,
    input logic [BYTE_W-1:0] out_byte,
    input logic              out_full,
    input logic              out_push,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              tx_ready
);
    // R8: no push into a full output FIFO
    a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        out_push |-> !out_full);

    // R8: a blocked byte stays put and the splitter stays occupied
    a_r8_hold_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && out_full) |=> ($stable(out_byte) && !tx_ready));

    // R8: a bus read always leaves a word pending for output
    a_r8_read_buffered: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> !tx_ready);

    // R9: never pop an empty input FIFO
    a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        in_pop |-> !in_empty);

    // R10: read and write strobes are exclusive
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
endmodule

bind hostcmd_bridge hcb_checker #(.BYTE_W(BYTE_W)) i_hcb_checker (
    .clk(clk), .rst_n(rst_n), .in_empty(in_empty), .in_pop(in_pop),
    .out_byte(out_byte), .out_full(out_full), .out_push(out_push),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .tx_ready(tx_ready)
);

// File: tb/test_hostcmd_bridge.sv
// Directed bench for the host command bridge with FIFO and bus models.
module test_hostcmd_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_N = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_empty = 1'b1;
    logic        in_pop;
    logic [7:0]  out_byte;
    logic        out_full = 1'b0;
    logic        out_push;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_wr;
    logic        bus_rd;
    logic [15:0] bus_rdata;

    // input FIFO model: tasks own iwp, monitor owns irp
    logic [7:0]  imem [MEM_N];
    int          iwp = 0;
    int          irp = 0;
    // output FIFO model: monitor owns owp, tasks own orp
    logic [7:0]  omem [MEM_N];
    int          owp = 0;
    int          orp = 0;
    int          cap = 64;
    bit          gap_mode = 1'b0;
    bit          gap_tick = 1'b0;
    // bus logs owned by monitor
    logic [15:0] wdat [MEM_N];
    logic [7:0]  wadr [MEM_N];
    int          wn = 0;
    int          rn = 0;
    int          bad_pop = 0;
    int          both_cnt = 0;
    int          bad_raddr = 0;
    logic [7:0]  rd_seq;
    logic [7:0]  rd_expect_addr = '0;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign bus_rdata = {bus_addr, rd_seq};

    hostcmd_bridge i_hostcmd_bridge (
        .clk(clk), .rst_n(rst_n),
        .in_byte(in_byte), .in_empty(in_empty), .in_pop(in_pop),
        .out_byte(out_byte), .out_full(out_full), .out_push(out_push),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    // Monitor: record pops, pushes and bus strobes at the clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_seq <= 8'h00;
        end else begin
            if (in_pop) begin
                if (irp >= iwp) bad_pop++;
                else irp++;
            end
            if (out_push) begin
                omem[owp] = out_byte;
                owp++;
            end
            if (bus_wr) begin
                wdat[wn] = bus_wdata;
                wadr[wn] = bus_addr;
                wn++;
            end
            if (bus_rd) begin
                if (bus_addr != rd_expect_addr) bad_raddr++;
                rn++;
                rd_seq <= rd_seq + 8'h01;
            end
            if (bus_rd && bus_wr) both_cnt++;
        end
    end

    // FIFO flag driver, away from the active edge
    always @(negedge clk) begin
        gap_tick = ~gap_tick;
        in_empty = (irp >= iwp) || (gap_mode && gap_tick);
        in_byte  = (irp < iwp) ? imem[irp] : 8'h00;
        out_full = (owp - orp) >= cap;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic put_word(input logic [15:0] w);
        imem[iwp]     = w[15:8];
        imem[iwp + 1] = w[7:0];
        iwp += 2;
    endtask

    task automatic settle();
        while (irp < iwp) @(negedge clk);
        repeat (30) @(negedge clk);
    endtask

    task automatic expect_word(input string req, input logic [15:0] w);
        check(owp - orp >= 2, req, owp - orp, 2);
        if (owp - orp >= 2) begin
            check(omem[orp] == w[15:8], req, omem[orp], w[15:8]);
            check(omem[orp + 1] == w[7:0], req, omem[orp + 1], w[7:0]);
            orp += 2;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(!bus_rd && !bus_wr, "R10 reset strobes", {bus_rd, bus_wr}, 0);
        check(!out_push && !in_pop, "R10 reset fifo strobes", {out_push, in_pop}, 0);
    endtask

    task automatic t_nop_ping();
        int w0 = wn;
        int r0 = rn;
        put_word(16'h0000);
        put_word(16'h0155);
        settle();
        check(owp - orp == 2, "R2 nop adds no bytes", owp - orp, 2);
        expect_word("R3 ping echo, R1 order", 16'h0155);
        check(wn == w0 && rn == r0, "R2 nop no bus", wn + rn, w0 + r0);
    endtask

    task automatic t_write();
        logic [15:0] d [3] = '{16'h1234, 16'hA1B2, 16'h00FF};
        int w0 = wn;
        put_word(16'h0342);
        put_word(16'h0003);
        for (int i = 0; i < 3; i++) put_word(d[i]);
        settle();
        check(wn - w0 == 3, "R4 write count", wn - w0, 3);
        for (int i = 0; i < 3; i++) begin
            check(wadr[w0 + i] == 8'h42, "R4 write addr", wadr[w0 + i], 8'h42);
            check(wdat[w0 + i] == d[i], "R4 write data R1", wdat[w0 + i], d[i]);
        end
        check(owp == orp, "R4 write no output", owp - orp, 0);
    endtask

    task automatic t_read();
        int r0 = rn;
        logic [7:0] s0 = rd_seq;
        rd_expect_addr = 8'h17;
        put_word(16'h0217);
        put_word(16'h0002);
        settle();
        check(rn - r0 == 2, "R5 read count", rn - r0, 2);
        expect_word("R5 read word0", {8'h17, s0});
        expect_word("R5 read word1", {8'h17, s0 + 8'h01});
        check(bad_raddr == 0, "R5 read addr", bad_raddr, 0);
    endtask

    task automatic t_zero();
        int w0 = wn;
        int r0 = rn;
        put_word(16'h0310);
        put_word(16'h0000);
        put_word(16'h0211);
        put_word(16'h0000);
        put_word(16'h01AA);
        settle();
        check(wn == w0 && rn == r0, "R6 zero count no bus", wn + rn, w0 + r0);
        check(owp - orp == 2, "R6 zero count no bytes", owp - orp, 2);
        expect_word("R6 next command decoded", 16'h01AA);
    endtask

    task automatic t_unknown();
        int w0 = wn;
        int r0 = rn;
        put_word(16'h7E33);
        put_word(16'h0199);
        settle();
        check(wn == w0 && rn == r0, "R7 unknown no bus", wn + rn, w0 + r0);
        check(owp - orp == 2, "R7 unknown no bytes", owp - orp, 2);
        expect_word("R7 following ping", 16'h0199);
    endtask

    task automatic t_stall();
        int r0 = rn;
        logic [7:0] s0 = rd_seq;
        rd_expect_addr = 8'h30;
        cap = 1;
        put_word(16'h0230);
        put_word(16'h0003);
        settle();
        check(owp - orp == 1, "R8 stalled bytes", owp - orp, 1);
        check(rn - r0 == 1, "R8 stalled reads", rn - r0, 1);
        check(out_byte == s0, "R8 held low byte", out_byte, s0);
        repeat (5) @(negedge clk);
        check(out_byte == s0 && !out_push, "R8 still held", out_byte, s0);
        cap = 64;
        repeat (30) @(negedge clk);
        check(rn - r0 == 3, "R8 reads after release", rn - r0, 3);
        for (int i = 0; i < 3; i++) expect_word("R8 no loss", {8'h30, s0 + 8'(i)});
    endtask

    task automatic t_gaps();
        int w0 = wn;
        gap_mode = 1'b1;
        put_word(16'h0305);
        put_word(16'h0002);
        put_word(16'hBEEF);
        put_word(16'h5A01);
        settle();
        gap_mode = 1'b0;
        check(wn - w0 == 2, "R9 gaps write count", wn - w0, 2);
        check(wdat[w0] == 16'hBEEF && wadr[w0] == 8'h05, "R9 gaps word0", wdat[w0], 16'hBEEF);
        check(wdat[w0 + 1] == 16'h5A01, "R9 gaps word1", wdat[w0 + 1], 16'h5A01);
        check(bad_pop == 0, "R9 no pop empty", bad_pop, 0);
        check(both_cnt == 0, "R10 exclusive strobes", both_cnt, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_nop_ping();
        t_write();
        t_read();
        t_zero();
        t_unknown();
        t_stall();
        t_gaps();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
        $finish;
    end
endmodule